// File: doc/BRIEF.md
# Byte-Wide Flash Command Decoder

This block is the device-side front end of a byte-wide flash memory. An external host drives chip-enable, write-enable and output-enable strobes (all active low), an address bus and a bidirectional data bus. The block samples the strobes in its own clock domain and finds the start and end of each write cycle. It keeps a command mode and decodes command bytes written on the data bus. A byte program goes through a setup byte followed by an address and data cycle. An erase needs a confirming second byte. Two verify modes read back through an address that an earlier write captured.

Reads are steered to the normal array location, to the byte last programmed, or to the byte chosen by the erase-verify command. The block issues single-cycle start pulses for program and erase toward an internal timer. A small behavioural register file stands in for the array: programming can only clear bits, and erasing sets every byte to all ones. The high-voltage supply is not modelled. A single input reports whether the programming voltage is present, and every write is ignored while it is low.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the block is in read mode, every array byte reads FFh, and neither start pulse is asserted.
- R2: The block drives the data bus only while chip-enable is low, output-enable is low and write-enable is high; in every other case the bus is high impedance.
- R3: In read mode a read returns the array byte at the address on the address bus.
- R4: A write of 40h followed by a second write cycle programs one byte, giving one pgm_start pulse. The stored byte becomes the old byte AND the written byte, so programming never sets a bit.
- R5: In the program data cycle, the address is the value present when write-enable falls and the data is the value present when write-enable rises.
- R6: Writing C0h enters program-verify mode. Reads then return the byte at the last programmed address, whatever is on the address bus.
- R7: Two consecutive writes of 20h give one erase_start pulse and set every array byte to FFh.
- R8: A write that follows a 20h setup and is not 20h gives no erase pulse, leaves the array unchanged, and returns the block to read mode.
- R9: Writing A0h enters erase-verify mode with the address captured in that write cycle. Reads then return that byte, whatever is on the address bus.
- R10: Writing 00h, or any byte that is not a recognised command, returns the block to read mode.
- R11: While vpp_hi is low, write cycles change neither the mode nor the array and give no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | High programming voltage present |
| addr | input | ADDR_W | Byte address |
| dq | inout | 8 | Bidirectional data bus |
| pgm_start | output | 1 | One-cycle program start pulse to the timer |
| erase_start | output | 1 | One-cycle erase start pulse to the timer |

## Verification
The bench builds the block with ADDR_W set to 3, which gives an eight-byte array. With that size, the check that an erase has set every byte to FFh covers the whole array by reading each address. The same size leaves enough spare addresses to show that each verify mode ignores the address bus. In the program data cycle the bench changes the address and the data between the two write-enable edges, so the falling-edge capture of the address and the rising-edge capture of the data are checked separately.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    M_READ, M_PSETUP, M_PVERIFY, M_ESETUP, M_EVERIFY
  } fmode_e;

  localparam logic [BYTE_W-1:0] OP_READ    = 8'h00;
  localparam logic [BYTE_W-1:0] OP_PSETUP  = 8'h40;
  localparam logic [BYTE_W-1:0] OP_PVERIFY = 8'hC0;
  localparam logic [BYTE_W-1:0] OP_ERASE   = 8'h20;
  localparam logic [BYTE_W-1:0] OP_EVERIFY = 8'hA0;

  // Mode selected by a command byte written outside setup modes.
  function automatic fmode_e decode_op(input logic [BYTE_W-1:0] op);
    case (op)
      OP_PSETUP:  return M_PSETUP;
      OP_PVERIFY: return M_PVERIFY;
      OP_ERASE:   return M_ESETUP;
      OP_EVERIFY: return M_EVERIFY;
      default:    return M_READ;
    endcase
  endfunction

  // Flash cells can only go from 1 to 0 when programmed.
  function automatic logic [BYTE_W-1:0] prog_merge(input logic [BYTE_W-1:0] old_b,
                                                   input logic [BYTE_W-1:0] new_b);
    return old_b & new_b;
  endfunction
endpackage

// File: rtl/fcmd_strobe.sv
module fcmd_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic wr_fall,
  output logic wr_rise
);
  logic wr_act, wr_act_q;

  assign wr_act = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_act_q <= 1'b0;
    else        wr_act_q <= wr_act;
  end

  assign wr_fall = wr_act && !wr_act_q;
  assign wr_rise = !wr_act && wr_act_q;
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_fall,
  input  logic                 wr_rise,
  input  logic                 vpp_hi,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BYTE_W-1:0]    din,
  output fmode_e               mode,
  output logic                 pgm_start,
  output logic                 erase_start,
  output logic [ADDR_W-1:0]    pgm_addr,
  output logic [BYTE_W-1:0]    pgm_data,
  output logic [ADDR_W-1:0]    vfy_addr
);
  logic [ADDR_W-1:0] addr_cap;
  logic              wr_ok;

  assign wr_ok = wr_rise && vpp_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_cap <= '0;
    else if (wr_fall) addr_cap <= addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= M_READ;
      pgm_start   <= 1'b0;
      erase_start <= 1'b0;
      pgm_addr    <= '0;
      pgm_data    <= '0;
      vfy_addr    <= '0;
    end else begin
      pgm_start   <= 1'b0;
      erase_start <= 1'b0;
      if (wr_ok) begin
        case (mode)
          M_PSETUP: begin
            pgm_addr  <= addr_cap;
            pgm_data  <= din;
            pgm_start <= 1'b1;
            mode      <= M_READ;
          end
          M_ESETUP: begin
            erase_start <= (din == OP_ERASE);
            mode        <= M_READ;
          end
          default: begin
            mode <= decode_op(din);
            if (din == OP_EVERIFY) vfy_addr <= addr_cap;
          end
        endcase
      end
    end
  end

  a_r4_pgm_from_setup: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> ($past(mode) == M_PSETUP) && $past(vpp_hi));
  a_r7_erase_pair: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> ($past(mode) == M_ESETUP) && ($past(din) == OP_ERASE));
  a_r11_no_vpp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !vpp_hi) |=> $stable(mode) && !pgm_start && !erase_start);
  a_r10_read_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && mode == M_READ && din == OP_READ) |=> mode == M_READ);
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_start, erase_start}));
endmodule

// File: rtl/fcmd_array.sv
module fcmd_array
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 erase_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [BYTE_W-1:0]    rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem[i] <= '1;
      else if (erase_en)                           mem[i] <= '1;
      else if (wr_en && wr_addr == ADDR_W'(i))     mem[i] <= prog_merge(mem[i], wr_data);
    end
  end

  assign rd_data = mem[rd_addr];

  a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase_en) |=> (mem[$past(wr_addr)] & ~$past(mem[wr_addr])) == '0);
  a_r7_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> (&mem[DEPTH-1]) && (&mem[0]));
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [7:0]        dq,
  output logic              pgm_start,
  output logic              erase_start
);
  logic              wr_fall, wr_rise, dq_en;
  fmode_e            mode;
  logic [ADDR_W-1:0] pgm_addr, vfy_addr, rd_addr;
  logic [BYTE_W-1:0] pgm_data, rd_data, din;

  assign din = dq;

  fcmd_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .wr_fall(wr_fall), .wr_rise(wr_rise)
  );

  fcmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_fall(wr_fall), .wr_rise(wr_rise),
    .vpp_hi(vpp_hi), .addr(addr), .din(din), .mode(mode),
    .pgm_start(pgm_start), .erase_start(erase_start),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data), .vfy_addr(vfy_addr)
  );

  always_comb begin
    case (mode)
      M_PVERIFY: rd_addr = pgm_addr;
      M_EVERIFY: rd_addr = vfy_addr;
      default:   rd_addr = addr;
    endcase
  end

  fcmd_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(pgm_start), .erase_en(erase_start),
    .wr_addr(pgm_addr), .wr_data(pgm_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign dq_en = !ce_n && !oe_n && we_n;
  assign dq    = dq_en ? rd_data : 'z;
endmodule

// File: tb/tb_flash_cmd_if.sv
`timescale 1ns/1ps
module tb_flash_cmd_if;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] drv = 8'h00;
  logic drv_en = 1'b0;
  wire  [7:0] dq;
  logic pgm_start, erase_start;
  int checks = 0, fails = 0, pgm_cnt = 0, ers_cnt = 0;
  bit done = 0;

  assign dq = drv_en ? drv : 8'hzz;
  always #2.5 clk = ~clk;

  flash_cmd_if #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .addr(addr), .dq(dq),
    .pgm_start(pgm_start), .erase_start(erase_start)
  );

  always @(posedge clk) begin
    if (pgm_start)   pgm_cnt++;
    if (erase_start) ers_cnt++;
  end

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chki(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One write cycle: address/data may change between the two we_n edges.
  task automatic wr(logic [AW-1:0] a_f, logic [AW-1:0] a_r, logic [7:0] d_f, logic [7:0] d_r);
    @(negedge clk); addr = a_f; drv = d_f; drv_en = 1'b1; ce_n = 1'b0;
    repeat (2) @(negedge clk); we_n = 1'b0;
    repeat (3) @(negedge clk); addr = a_r; drv = d_r;
    repeat (2) @(negedge clk); we_n = 1'b1;
    repeat (3) @(negedge clk); ce_n = 1'b1; drv_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] c);
    wr('0, '0, c, c);
  endtask

  task automatic rd(string tag, logic [AW-1:0] a, logic [7:0] exp);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    chk8(tag, dq, exp);
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk8("R1 idle bus", dq, 8'hzz);
    chki("R1 no pulses", pgm_cnt + ers_cnt, 0);
    for (int i = 0; i < (1 << AW); i++) rd("R1 R3 erased after reset", AW'(i), 8'hFF);
  endtask

  task automatic t_bus();
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    repeat (2) @(negedge clk); chk8("R2 ce high", dq, 8'hzz);
    ce_n = 1'b0; oe_n = 1'b1;
    repeat (2) @(negedge clk); chk8("R2 oe high", dq, 8'hzz);
    oe_n = 1'b0; we_n = 1'b0;
    @(negedge clk); chk8("R2 we low", dq, 8'hzz);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_program();
    int p0 = pgm_cnt;
    cmd(8'h40); wr(3'd5, 3'd5, 8'h3C, 8'h3C);
    chki("R4 one pgm pulse", pgm_cnt - p0, 1);
    rd("R4 R3 programmed byte", 3'd5, 8'h3C);
    cmd(8'h40); wr(3'd5, 3'd5, 8'hF0, 8'hF0);
    rd("R4 bits only cleared", 3'd5, 8'h30);
  endtask

  task automatic t_edges();
    cmd(8'h40); wr(3'd6, 3'd7, 8'hA5, 8'h5A);
    rd("R5 data from rising edge at fall addr", 3'd6, 8'h5A);
    rd("R5 rise addr untouched", 3'd7, 8'hFF);
  endtask

  task automatic t_pverify();
    cmd(8'h40); wr(3'd5, 3'd5, 8'h30, 8'h30);
    cmd(8'hC0);
    rd("R6 verify ignores addr", 3'd0, 8'h30);
    cmd(8'h00);
    rd("R10 00h back to read", 3'd0, 8'hFF);
  endtask

  task automatic t_erase();
    int e0 = ers_cnt;
    cmd(8'h20); cmd(8'h20);
    chki("R7 one erase pulse", ers_cnt - e0, 1);
    for (int i = 0; i < (1 << AW); i++) rd("R7 erased", AW'(i), 8'hFF);
  endtask

  task automatic t_cancel();
    int e0;
    cmd(8'h40); wr(3'd2, 3'd2, 8'h11, 8'h11);
    e0 = ers_cnt;
    cmd(8'h20); cmd(8'h55);
    chki("R8 no erase pulse", ers_cnt - e0, 0);
    rd("R8 array kept, read mode", 3'd2, 8'h11);
  endtask

  task automatic t_everify();
    wr(3'd2, 3'd2, 8'hA0, 8'hA0);
    rd("R9 erase verify byte", 3'd4, 8'h11);
    cmd(8'h77);
    rd("R10 unknown back to read", 3'd4, 8'hFF);
  endtask

  task automatic t_novpp();
    int p0 = pgm_cnt;
    int e0 = ers_cnt;
    vpp_hi = 1'b0;
    cmd(8'h40); wr(3'd3, 3'd3, 8'h00, 8'h00);
    cmd(8'h20); cmd(8'h20);
    chki("R11 no pulses", (pgm_cnt - p0) + (ers_cnt - e0), 0);
    rd("R11 array kept", 3'd3, 8'hFF);
    rd("R11 array kept", 3'd2, 8'h11);
    cmd(8'hC0);
    rd("R11 mode kept", 3'd1, 8'hFF);
    vpp_hi = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_bus();
    t_program();
    t_edges();
    t_pverify();
    t_erase();
    t_cancel();
    t_everify();
    t_novpp();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule